// File: doc/BRIEF.md
# Channel Processor Status Register

This block is the status word of a small channel processor. It holds five condition flags, a channel-enable bit, an interrupt-enable bit and an 8-bit data pointer. The execution stage can update it in three ways, and all three may arrive in the same cycle: an explicit write of the whole word, a set or clear command on a single bit, and implicit flag results from the instruction that just executed. The block merges them bit by bit with a fixed precedence. Results produced by the instruction beat a bit command, and a bit command beats the explicit write data.

The data pointer selects a 64-word segment of the channel's private data memory. The block joins the pointer with a 6-bit offset to form a 14-bit word address. The offset comes from an instruction immediate or from a register.

The block also judges each incoming service request against the enable bits and the priority of the channel that is running. It then reports, one cycle later, whether the request forces an error exit, is accepted, or also suspends the running channel.

Top module: `chan_status_reg`

## Requirements
- R1: An explicit write (`wrEn`) loads bits 6:0 and the data pointer at bits 15:8 from `wrData`. Bit 7 and bits 31:16 always read zero. Bit map: Z=0, N=1, C=2, V=3, CN1Z=4, IEN=5, CEN=6.
- R2: With no write, no bit command and an all-zero `flagUpdMask`, `statusOut` keeps its value.
- R3: A flag whose `flagUpdMask` bit is set (mask bit i targets status bit i, for i from 0 to 4) takes `flagUpdVal[i]` on the next edge. This overrides an explicit write and a bit command to the same bit in the same cycle. The other written bits still load.
- R4: Writing 0x0000FF07 together with an implicit update of Z and N to 0 leaves 0x0000FF04.
- R5: `pramAddr` is combinationally {data pointer, offset}. The offset is `offImm` when `offSel`=0 and `offReg` when `offSel`=1.
- R6: A bit command sets (`bitCmdSet`=1) or clears status bit `bitCmdIdx` for an index from 0 to 6. Index 7 has no effect. The command changes only that bit, never the data pointer, and overrides explicit write data on that bit.
- R7: A request (`reqValid`) seen while CEN=0 raises `errExit` and `hostErrIrq` one cycle later, with `reqAccept` and `suspend` low.
- R8: While IEN=0 a request never raises `suspend`.
- R9: With CEN=1, IEN=1 and `runActive`=1, a request with `reqPrio` strictly greater than `runPrio` raises `suspend` and `reqAccept` one cycle later. An equal or lower priority raises neither.
- R10: With CEN=1 and `runActive`=0, a request raises `reqAccept` one cycle later, with `suspend` low.
- R11: The request verdict uses CEN and IEN as they stood before any same-cycle write. The verdict outputs are one-cycle pulses.
- R12: A synchronous active-high `rst` clears the status word and all verdict outputs on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Explicit write strobe |
| wrData | input | 32 | Explicit write data |
| flagUpdMask | input | 5 | Implicit flag update enables, bit i targets status bit i |
| flagUpdVal | input | 5 | Implicit flag result values |
| bitCmdEn | input | 1 | Single-bit set/clear command strobe |
| bitCmdSet | input | 1 | 1 sets, 0 clears the indexed bit |
| bitCmdIdx | input | 3 | Status bit index for the bit command |
| offSel | input | 1 | Offset source: 0 immediate, 1 register |
| offImm | input | 6 | Immediate offset |
| offReg | input | 6 | Register offset |
| reqValid | input | 1 | Service request present |
| reqPrio | input | 4 | Priority of the incoming request |
| runActive | input | 1 | A channel program is running |
| runPrio | input | 4 | Priority of the running channel |
| statusOut | output | 32 | Current status word |
| pramAddr | output | 14 | Data memory word address |
| errExit | output | 1 | Error exit pulse for a disabled channel |
| hostErrIrq | output | 1 | Error interrupt pulse toward the host |
| suspend | output | 1 | Running channel must be suspended |
| reqAccept | output | 1 | Request accepted |

## Verification
A wrong merge of the bit precedence shows on `statusOut` on the first edge after the colliding update, so every collision test reads the word one cycle later. A corrupted data pointer appears at once on the upper bits of `pramAddr` and on `statusOut[15:8]`. A wrong CEN or IEN value is not visible until a request arrives. That request is then misjudged, one cycle after it is sampled. For this reason each enable setting is followed by requests of higher, equal and lower priority, and by a request in the same cycle as a write that flips the enable bit.

// File: rtl/chan_status_pkg.sv
package chan_status_pkg;
  localparam int STS_W    = 32;
  localparam int DPTR_W   = 8;
  localparam int OFF_W    = 6;
  localparam int ADDR_W   = DPTR_W + OFF_W;
  localparam int FLAG_N   = 5;
  localparam int CTRL_N   = 7;
  localparam int DPTR_LSB = 8;
  localparam int IDX_W    = 3;
  localparam int HI_ZERO  = STS_W - DPTR_LSB - DPTR_W;
  localparam int GAP_ZERO = DPTR_LSB - CTRL_N;

  localparam int BIT_Z    = 0;
  localparam int BIT_N    = 1;
  localparam int BIT_C    = 2;
  localparam int BIT_V    = 3;
  localparam int BIT_CN1Z = 4;
  localparam int BIT_IEN  = 5;
  localparam int BIT_CEN  = 6;

  typedef struct packed {
    logic [CTRL_N-1:0] bitWe;
    logic [CTRL_N-1:0] bitVal;
    logic              dptrWe;
    logic [DPTR_W-1:0] dptrVal;
  } stsStrobe_t;

  typedef enum logic [1:0] {
    REQ_NONE    = 2'd0,
    REQ_ERROR   = 2'd1,
    REQ_TAKE    = 2'd2,
    REQ_PREEMPT = 2'd3
  } reqVerdict_t;
endpackage

// File: rtl/chan_status_ctrl.sv
module chan_status_ctrl
  import chan_status_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [CTRL_N-1:0] wrLow,
  input  logic [DPTR_W-1:0] wrDptr,
  input  logic [FLAG_N-1:0] flagUpdMask,
  input  logic [FLAG_N-1:0] flagUpdVal,
  input  logic              bitCmdEn,
  input  logic              bitCmdSet,
  input  logic [IDX_W-1:0]  bitCmdIdx,
  input  logic              reqValid,
  input  logic [PRIO_W-1:0] reqPrio,
  input  logic              runActive,
  input  logic [PRIO_W-1:0] runPrio,
  input  logic              cenNow,
  input  logic              ienNow,
  output stsStrobe_t        strobe,
  output logic              errExit,
  output logic              hostErrIrq,
  output logic              suspend,
  output logic              reqAccept
);
  logic        prioHigher;
  reqVerdict_t verdictD;
  reqVerdict_t verdictQ;

  // Precedence ladder: write data first, bit command on top, instruction flags last.
  always_comb begin
    strobe = '0;
    if (wrEn) begin
      strobe.bitWe   = '1;
      strobe.bitVal  = wrLow;
      strobe.dptrWe  = 1'b1;
      strobe.dptrVal = wrDptr;
    end
    if (bitCmdEn && (int'(bitCmdIdx) < CTRL_N)) begin
      strobe.bitWe[bitCmdIdx]  = 1'b1;
      strobe.bitVal[bitCmdIdx] = bitCmdSet;
    end
    for (int i = 0; i < FLAG_N; i++) begin
      if (flagUpdMask[i]) begin
        strobe.bitWe[i]  = 1'b1;
        strobe.bitVal[i] = flagUpdVal[i];
      end
    end
  end

  assign prioHigher = (reqPrio > runPrio);

  always_comb begin
    verdictD = REQ_NONE;
    if (reqValid) begin
      if (!cenNow)                               verdictD = REQ_ERROR;
      else if (!runActive)                       verdictD = REQ_TAKE;
      else if (ienNow && prioHigher)             verdictD = REQ_PREEMPT;
      else                                       verdictD = REQ_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) verdictQ <= REQ_NONE;
    else     verdictQ <= verdictD;
  end

  assign errExit    = (verdictQ == REQ_ERROR);
  assign hostErrIrq = (verdictQ == REQ_ERROR);
  assign suspend    = (verdictQ == REQ_PREEMPT);
  assign reqAccept  = (verdictQ == REQ_TAKE) || (verdictQ == REQ_PREEMPT);

  AST_PREEMPT_NEEDS_IEN: assert property (@(posedge clk) disable iff (rst)
    reqValid && !ienNow |=> !suspend); // R8
  AST_DISABLED_ERRS: assert property (@(posedge clk) disable iff (rst)
    reqValid && !cenNow |=> errExit && hostErrIrq && !reqAccept); // R7
endmodule

// File: rtl/chan_status_dp.sv
module chan_status_dp
  import chan_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  stsStrobe_t        strobe,
  input  logic              offSel,
  input  logic [OFF_W-1:0]  offImm,
  input  logic [OFF_W-1:0]  offReg,
  output logic [STS_W-1:0]  statusOut,
  output logic [ADDR_W-1:0] pramAddr,
  output logic              cenNow,
  output logic              ienNow
);
  logic [CTRL_N-1:0] ctrlBitsQ;
  logic [DPTR_W-1:0] dptrQ;
  logic [OFF_W-1:0]  offSelected;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlBitsQ <= '0;
      dptrQ     <= '0;
    end else begin
      for (int b = 0; b < CTRL_N; b++) begin
        if (strobe.bitWe[b]) ctrlBitsQ[b] <= strobe.bitVal[b];
      end
      if (strobe.dptrWe) dptrQ <= strobe.dptrVal;
    end
  end

  assign offSelected = offSel ? offReg : offImm;
  assign pramAddr    = {dptrQ, offSelected};

  assign statusOut = {{HI_ZERO{1'b0}}, dptrQ, {GAP_ZERO{1'b0}}, ctrlBitsQ};
  assign cenNow    = ctrlBitsQ[BIT_CEN];
  assign ienNow    = ctrlBitsQ[BIT_IEN];

  AST_DPTR_GATED: assert property (@(posedge clk) disable iff (rst)
    !strobe.dptrWe |=> $stable(dptrQ)); // R6
endmodule

// File: rtl/chan_status_reg.sv
module chan_status_reg
  import chan_status_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  input  logic [4:0]        flagUpdMask,
  input  logic [4:0]        flagUpdVal,
  input  logic              bitCmdEn,
  input  logic              bitCmdSet,
  input  logic [2:0]        bitCmdIdx,
  input  logic              offSel,
  input  logic [5:0]        offImm,
  input  logic [5:0]        offReg,
  input  logic              reqValid,
  input  logic [PRIO_W-1:0] reqPrio,
  input  logic              runActive,
  input  logic [PRIO_W-1:0] runPrio,
  output logic [31:0]       statusOut,
  output logic [13:0]       pramAddr,
  output logic              errExit,
  output logic              hostErrIrq,
  output logic              suspend,
  output logic              reqAccept
);
  stsStrobe_t strobe;
  logic       cenNow;
  logic       ienNow;
  logic       unusedWrBits;

  assign unusedWrBits = ^{wrData[STS_W-1:DPTR_LSB+DPTR_W], wrData[DPTR_LSB-1:CTRL_N]};

  chan_status_ctrl #(.PRIO_W(PRIO_W)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .wrEn        (wrEn),
    .wrLow       (wrData[CTRL_N-1:0]),
    .wrDptr      (wrData[DPTR_LSB +: DPTR_W]),
    .flagUpdMask (flagUpdMask),
    .flagUpdVal  (flagUpdVal),
    .bitCmdEn    (bitCmdEn),
    .bitCmdSet   (bitCmdSet),
    .bitCmdIdx   (bitCmdIdx),
    .reqValid    (reqValid),
    .reqPrio     (reqPrio),
    .runActive   (runActive),
    .runPrio     (runPrio),
    .cenNow      (cenNow),
    .ienNow      (ienNow),
    .strobe      (strobe),
    .errExit     (errExit),
    .hostErrIrq  (hostErrIrq),
    .suspend     (suspend),
    .reqAccept   (reqAccept)
  );

  chan_status_dp dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .offSel    (offSel),
    .offImm    (offImm),
    .offReg    (offReg),
    .statusOut (statusOut),
    .pramAddr  (pramAddr),
    .cenNow    (cenNow),
    .ienNow    (ienNow)
  );

  AST_IMPL_WINS: assert property (@(posedge clk) disable iff (rst)
    (|flagUpdMask) |=> (((statusOut[FLAG_N-1:0] ^ $past(flagUpdVal)) & $past(flagUpdMask)) == '0)); // R3
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wrEn && !bitCmdEn && (flagUpdMask == '0) |=> $stable(statusOut)); // R2
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(errExit && (suspend || reqAccept))); // R7
  AST_VERDICT_PULSE: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !errExit && !suspend && !reqAccept); // R11
endmodule

// File: tb/chan_status_reg_tb.sv
module chan_status_reg_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wrEn;
  logic [31:0] wrData;
  logic [4:0]  flagUpdMask;
  logic [4:0]  flagUpdVal;
  logic        bitCmdEn;
  logic        bitCmdSet;
  logic [2:0]  bitCmdIdx;
  logic        offSel;
  logic [5:0]  offImm;
  logic [5:0]  offReg;
  logic        reqValid;
  logic [3:0]  reqPrio;
  logic        runActive;
  logic [3:0]  runPrio;
  logic [31:0] statusOut;
  logic [13:0] pramAddr;
  logic        errExit;
  logic        hostErrIrq;
  logic        suspend;
  logic        reqAccept;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_status_reg dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
    .flagUpdMask(flagUpdMask), .flagUpdVal(flagUpdVal),
    .bitCmdEn(bitCmdEn), .bitCmdSet(bitCmdSet), .bitCmdIdx(bitCmdIdx),
    .offSel(offSel), .offImm(offImm), .offReg(offReg),
    .reqValid(reqValid), .reqPrio(reqPrio), .runActive(runActive), .runPrio(runPrio),
    .statusOut(statusOut), .pramAddr(pramAddr), .errExit(errExit),
    .hostErrIrq(hostErrIrq), .suspend(suspend), .reqAccept(reqAccept)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    wrEn = 0; wrData = '0; flagUpdMask = '0; flagUpdVal = '0;
    bitCmdEn = 0; bitCmdSet = 0; bitCmdIdx = '0;
    reqValid = 0; reqPrio = '0; runActive = 0; runPrio = '0;
  endtask

  task automatic doWrite(input logic [31:0] d);
    wrEn = 1; wrData = d; tick(); idle();
  endtask

  task automatic chkVerdict(input string req, input logic e, input logic s, input logic a);
    chk(req, "errExit", {31'b0, errExit}, {31'b0, e});
    chk(req, "hostErrIrq", {31'b0, hostErrIrq}, {31'b0, e});
    chk(req, "suspend", {31'b0, suspend}, {31'b0, s});
    chk(req, "reqAccept", {31'b0, reqAccept}, {31'b0, a});
  endtask

  task automatic sendReq(input logic run, input logic [3:0] rp, input logic [3:0] cp);
    reqValid = 1; runActive = run; reqPrio = rp; runPrio = cp; tick(); idle();
  endtask

  task automatic testReset();
    rst = 1; idle(); offSel = 0; offImm = '0; offReg = '0;
    tick(); tick(); rst = 0;
    chk("R12", "status after reset", statusOut, 32'h0);
    chkVerdict("R12", 0, 0, 0);
  endtask

  task automatic testWrite();
    doWrite(32'hABCDC5FF);
    chk("R1", "reserved bits masked", statusOut, 32'h0000C57F);
    tick(); tick(); tick();
    chk("R2", "hold while idle", statusOut, 32'h0000C57F);
  endtask

  task automatic testPrecedence();
    wrEn = 1; wrData = 32'h0000FF07; flagUpdMask = 5'b00011; flagUpdVal = 5'b00000;
    tick(); idle();
    chk("R4", "move result example", statusOut, 32'h0000FF04);
    wrEn = 1; wrData = 32'h00001200; flagUpdMask = 5'b01100; flagUpdVal = 5'b01100;
    bitCmdEn = 1; bitCmdSet = 0; bitCmdIdx = 3'd2;
    tick(); idle();
    chk("R3", "implicit beats write and bit command", statusOut, 32'h0000120C);
    flagUpdMask = 5'b10000; flagUpdVal = 5'b10000;
    tick(); idle();
    chk("R3", "implicit update alone", statusOut, 32'h0000121C);
  endtask

  task automatic testBitCmd();
    bitCmdEn = 1; bitCmdSet = 1; bitCmdIdx = 3'd6; tick(); idle();
    chk("R6", "set index 6", statusOut, 32'h0000125C);
    bitCmdEn = 1; bitCmdSet = 0; bitCmdIdx = 3'd3; tick(); idle();
    chk("R6", "clear index 3", statusOut, 32'h00001254);
    bitCmdEn = 1; bitCmdSet = 1; bitCmdIdx = 3'd7; tick(); idle();
    chk("R6", "index 7 ignored", statusOut, 32'h00001254);
    wrEn = 1; wrData = 32'h00000000; bitCmdEn = 1; bitCmdSet = 1; bitCmdIdx = 3'd5;
    tick(); idle();
    chk("R6", "bit command beats write data", statusOut, 32'h00000020);
  endtask

  task automatic testAddr();
    doWrite(32'h0000A560);
    offSel = 0; offImm = 6'h3F; offReg = 6'h01; #1;
    chk("R5", "address from immediate", {18'b0, pramAddr}, 32'h297F);
    offSel = 1; #1;
    chk("R5", "address from register", {18'b0, pramAddr}, 32'h2941);
    offSel = 0; offImm = 6'h00; #1;
    chk("R5", "segment base", {18'b0, pramAddr}, 32'h2940);
  endtask

  task automatic testPreempt();
    sendReq(1, 4'd5, 4'd3);
    chkVerdict("R9", 0, 1, 1);
    tick();
    chkVerdict("R11", 0, 0, 0);
    sendReq(1, 4'd4, 4'd4);
    chkVerdict("R9", 0, 0, 0);
    sendReq(1, 4'd2, 4'd9);
    chkVerdict("R9", 0, 0, 0);
    sendReq(0, 4'd1, 4'd9);
    chkVerdict("R10", 0, 0, 1);
  endtask

  task automatic testIenOff();
    doWrite(32'h0000A540);
    sendReq(1, 4'd15, 4'd0);
    chkVerdict("R8", 0, 0, 0);
    sendReq(0, 4'd15, 4'd0);
    chkVerdict("R10", 0, 0, 1);
  endtask

  task automatic testDisabled();
    doWrite(32'h0000A520);
    sendReq(1, 4'd15, 4'd0);
    chkVerdict("R7", 1, 0, 0);
    tick();
    chkVerdict("R11", 0, 0, 0);
    wrEn = 1; wrData = 32'h0000A540; reqValid = 1; runActive = 0;
    tick(); idle();
    chkVerdict("R11", 1, 0, 0);
    chk("R11", "write landed", statusOut, 32'h0000A540);
    wrEn = 1; wrData = 32'h0000A500; reqValid = 1; runActive = 0;
    tick(); idle();
    chkVerdict("R11", 0, 0, 1);
  endtask

  task automatic testMidReset();
    doWrite(32'h0000A560);
    rst = 1; wrEn = 1; wrData = 32'h0000FFFF; reqValid = 1;
    tick(); rst = 0; idle();
    chk("R12", "status cleared", statusOut, 32'h0);
    chkVerdict("R12", 0, 0, 0);
  endtask

  initial begin
    testReset();
    testWrite();
    testPrecedence();
    testBitCmd();
    testAddr();
    testPreempt();
    testIenOff();
    testDisabled();
    testMidReset();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule